// File: doc/BRIEF.md
# Breakpoint Debug Register Bank

This block holds the debug state of a processor core: four breakpoint address slots, one sticky event status word and one control word. Software reaches them through a 3-bit register number with read and write strobes. Each access is checked against the current privilege level, against an optional trap-on-access guard and against an alias rule for two legacy register numbers. A rejected access completes nothing and raises the matching fault or debug request.

Separate event pulses update the status word: per-slot breakpoint matches, single step, a task-switch trap and a bus-lock trap. A task-switch pulse removes the per-task slot enables and keeps the all-task enables. An exception-entry strobe records that the handler was entered and drops the access guard, so the handler can reach the registers. The block does no address comparison; a separate comparator supplies the match vector.

Top module: `brkpt_regbank`

## Requirements
- R1: Register numbers 0 to 3 select the address slots, 6 the status word and 7 the control word. With `ext_en` low, numbers 4 and 5 act as 6 and 7. A granted read returns the stored value, and a slot narrower than 32 bits is zero-extended. A granted write takes effect at the next rising edge. Read data is 0 when no granted read is present.
- R2: Any read or write with `cpl` not equal to 0 raises `prot_fault` in the same cycle. It returns read data 0 and changes no register.
- R3: When control bit 13 is 1, an access at `cpl` 0 that is not undefined raises `dbg_req` and completes nothing (read data 0, no write).
- R4: After a cycle with `exc_entry` high, status bit 13 is 1 and control bit 13 is 0.
- R5: `bp_hit[i]` sets status bit i, whether or not slot i is enabled. `step_evt` sets status bit 14 and `trap_evt` sets status bit 15.
- R6: Status bits 0 to 3 and 13 to 15 are never cleared by hardware; only a granted software write clears them.
- R7: `lock_evt` clears status bit 11 (the bit is active low). Only a granted software write sets it back to 1.
- R8: `task_sw` clears control bits 0, 2, 4 and 6 (per-task enables). It leaves bits 1, 3, 5, 7 (all-task enables) and all other bits unchanged.
- R9: Control bit 10 always reads 1, and control bits 11, 12, 14 and 15 always read 0, whatever is written.
- R10: Status bits 4 to 10 and 16 to 31 always read 1, and status bit 12 always reads 0, whatever is written. Bit 16 is 1 because no transactional feature is present.
- R11: With `ext_en` high, an access to number 4 or 5 at `cpl` 0 raises `undef_fault` and completes nothing. Priority among the faults is privilege, then undefined, then the control-bit-13 trap. At most one fault flag is high.
- R12: After reset, the address slots read 0, status reads 0xFFFF0FF0 and control reads 0x00000400.
- R13: `dbg_req` is also high in any cycle with `step_evt`, `trap_evt` or `lock_evt` high. It is also high when some `bp_hit[i]` is high while control bit 2i or 2i+1 is 1. In the same cycle as a software write, the event updates of R4 to R8 take effect on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_num | input | 3 | Register number of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| cpl | input | 2 | Current privilege level, 0 is most privileged |
| ext_en | input | 1 | Debug extension enable, turns off aliasing of 4 and 5 |
| bp_hit | input | 4 | Breakpoint match pulses, one per slot |
| step_evt | input | 1 | Single-step event pulse |
| trap_evt | input | 1 | Task-switch trap event pulse |
| lock_evt | input | 1 | Bus-lock trap event pulse |
| task_sw | input | 1 | Task switch pulse |
| exc_entry | input | 1 | Debug handler entry strobe |
| prot_fault | output | 1 | Access rejected for privilege |
| undef_fault | output | 1 | Access to a legacy number with extensions on |
| dbg_req | output | 1 | Debug exception request |

## Verification
Some rules hold on every cycle, and the checker watches them all the time: the fixed bits of both words, fault exclusivity, the privilege and access-guard rejections, and the next-cycle effects of handler entry and task switch. It also watches that the sticky status bits fall, and that bit 11 rises, only after a write strobe. Other behaviour only shows in the bench's sequences against its reference model. This covers aliasing, zero extension of narrow slots and the merge of events with a write in the same cycle. It also covers `dbg_req` following slot enables, and the exact values read back after reset, after events and after software clears.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

   localparam int unsigned REG_W = 32;
   localparam int unsigned SLOTS = 4;
   localparam int unsigned NUM_W = 3;

   // status bit positions
   localparam int unsigned ST_LOCK   = 11;
   localparam int unsigned ST_DETECT = 13;
   localparam int unsigned ST_STEP   = 14;
   localparam int unsigned ST_TRAP   = 15;
   localparam int unsigned ST_TXN    = 16;

   // control bit positions and masks
   localparam int unsigned CT_GUARD = 13;
   localparam logic [REG_W-1:0] CTL_WMASK = 32'hFFFF_23FF;
   localparam logic [REG_W-1:0] CTL_FIXED = 32'h0000_0400;
   localparam logic [REG_W-1:0] CTL_LOCAL = 32'h0000_0055;

   typedef enum logic [2:0] {
      SEL_BP0  = 3'd0,
      SEL_BP1  = 3'd1,
      SEL_BP2  = 3'd2,
      SEL_BP3  = 3'd3,
      SEL_NONE = 3'd4,
      SEL_STAT = 3'd6,
      SEL_CTRL = 3'd7
   } reg_sel_e;

   function automatic logic [REG_W-1:0] stat_wmask(input bit has_lock, input bit has_txn);
      logic [REG_W-1:0] m;
      m = 32'h0000_E00F;
      m[ST_LOCK] = has_lock;
      m[ST_TXN]  = has_txn;
      return m;
   endfunction

   function automatic logic [REG_W-1:0] stat_fixed(input bit has_lock, input bit has_txn);
      logic [REG_W-1:0] f;
      f = 32'hFFFE_07F0;
      f[ST_LOCK] = !has_lock;
      f[ST_TXN]  = !has_txn;
      return f;
   endfunction

endpackage

// File: rtl/brkpt_access_ctl.sv
module brkpt_access_ctl
   import brkpt_pkg::*;
#(
   parameter int unsigned PRIV_W = 2
) (
   input  logic [NUM_W-1:0]  reg_num,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [PRIV_W-1:0] cpl,
   input  logic              ext_en,
   input  logic              guard_on,
   output logic              prot_fault,
   output logic              undef_fault,
   output logic              guard_trap,
   output logic              rd_ok,
   output logic              wr_ok,
   output reg_sel_e          sel
);

   logic access;
   logic legacy_num;
   logic granted;

   assign access      = rd_en | wr_en;
   assign legacy_num  = (reg_num == 3'd4) || (reg_num == 3'd5);
   assign prot_fault  = access && (cpl != '0);
   assign undef_fault = access && !prot_fault && ext_en && legacy_num;
   assign guard_trap  = access && !prot_fault && !undef_fault && guard_on;
   assign granted     = access && !prot_fault && !undef_fault && !guard_trap;
   assign rd_ok       = granted && rd_en;
   assign wr_ok       = granted && wr_en;

   always_comb begin
      case (reg_num)
         3'd0:    sel = SEL_BP0;
         3'd1:    sel = SEL_BP1;
         3'd2:    sel = SEL_BP2;
         3'd3:    sel = SEL_BP3;
         3'd4:    sel = ext_en ? SEL_NONE : SEL_STAT;
         3'd5:    sel = ext_en ? SEL_NONE : SEL_CTRL;
         3'd6:    sel = SEL_STAT;
         default: sel = SEL_CTRL;
      endcase
   end

endmodule

// File: rtl/brkpt_stat_reg.sv
module brkpt_stat_reg
   import brkpt_pkg::*;
#(
   parameter bit HAS_LOCK = 1'b1,
   parameter bit HAS_TXN  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic [REG_W-1:0] wdata,
   input  logic [SLOTS-1:0] bp_hit,
   input  logic             step_evt,
   input  logic             trap_evt,
   input  logic             lock_evt,
   input  logic             exc_entry,
   output logic [REG_W-1:0] stat_q
);

   localparam logic [REG_W-1:0] WMASK = stat_wmask(HAS_LOCK, HAS_TXN);
   localparam logic [REG_W-1:0] FIXED = stat_fixed(HAS_LOCK, HAS_TXN);
   localparam logic [REG_W-1:0] RSTV  = FIXED | (WMASK & 32'h0001_0800);

   logic             lock_clr;
   logic [REG_W-1:0] nxt;

   generate
      if (HAS_LOCK) begin : g_lock
         assign lock_clr = lock_evt;
      end else begin : g_nolock
         logic unused_lock;
         assign lock_clr    = 1'b0;
         assign unused_lock = lock_evt;
      end
   endgenerate

   always_comb begin
      nxt = stat_q;
      if (wr_ok) nxt = (stat_q & ~WMASK) | (wdata & WMASK);
      nxt[SLOTS-1:0] = nxt[SLOTS-1:0] | bp_hit;
      if (step_evt)  nxt[ST_STEP]   = 1'b1;
      if (trap_evt)  nxt[ST_TRAP]   = 1'b1;
      if (exc_entry) nxt[ST_DETECT] = 1'b1;
      if (lock_clr)  nxt[ST_LOCK]   = 1'b0;
      nxt = (nxt & WMASK) | FIXED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= RSTV;
      else        stat_q <= nxt;
   end

endmodule

// File: rtl/brkpt_ctl_reg.sv
module brkpt_ctl_reg
   import brkpt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic [REG_W-1:0] wdata,
   input  logic             task_sw,
   input  logic             exc_entry,
   output logic [REG_W-1:0] ctl_q
);

   logic [REG_W-1:0] nxt;

   always_comb begin
      nxt = ctl_q;
      if (wr_ok)     nxt = (ctl_q & ~CTL_WMASK) | (wdata & CTL_WMASK);
      if (task_sw)   nxt = nxt & ~CTL_LOCAL;
      if (exc_entry) nxt[CT_GUARD] = 1'b0;
      nxt = (nxt & CTL_WMASK) | CTL_FIXED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= CTL_FIXED;
      else        ctl_q <= nxt;
   end

endmodule

// File: rtl/brkpt_regbank.sv
module brkpt_regbank
   import brkpt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned PRIV_W   = 2,
   parameter bit          HAS_LOCK = 1'b1,
   parameter bit          HAS_TXN  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_W-1:0]  reg_num,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [PRIV_W-1:0] cpl,
   input  logic              ext_en,
   input  logic [SLOTS-1:0]  bp_hit,
   input  logic              step_evt,
   input  logic              trap_evt,
   input  logic              lock_evt,
   input  logic              task_sw,
   input  logic              exc_entry,
   output logic              prot_fault,
   output logic              undef_fault,
   output logic              dbg_req
);

   if (ADDR_W < 1 || ADDR_W > REG_W) begin : g_bad_addr_w
      $error("brkpt_regbank: ADDR_W must be within 1..32");
   end
   if (PRIV_W < 1) begin : g_bad_priv_w
      $error("brkpt_regbank: PRIV_W must be at least 1");
   end

   reg_sel_e         sel;
   logic             rd_ok;
   logic             wr_ok;
   logic             guard_trap;
   logic [REG_W-1:0] stat_q;
   logic [REG_W-1:0] ctl_q;
   logic [REG_W-1:0] bp_rd [SLOTS];
   logic [SLOTS-1:0] slot_en;
   logic [REG_W-1:0] rd_mux;

   brkpt_access_ctl #(.PRIV_W(PRIV_W)) i_access (
      .reg_num     (reg_num),
      .rd_en       (rd_en),
      .wr_en       (wr_en),
      .cpl         (cpl),
      .ext_en      (ext_en),
      .guard_on    (ctl_q[CT_GUARD]),
      .prot_fault  (prot_fault),
      .undef_fault (undef_fault),
      .guard_trap  (guard_trap),
      .rd_ok       (rd_ok),
      .wr_ok       (wr_ok),
      .sel         (sel)
   );

   brkpt_stat_reg #(.HAS_LOCK(HAS_LOCK), .HAS_TXN(HAS_TXN)) i_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ok     (wr_ok && (sel == SEL_STAT)),
      .wdata     (wr_data),
      .bp_hit    (bp_hit),
      .step_evt  (step_evt),
      .trap_evt  (trap_evt),
      .lock_evt  (lock_evt),
      .exc_entry (exc_entry),
      .stat_q    (stat_q)
   );

   brkpt_ctl_reg i_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ok     (wr_ok && (sel == SEL_CTRL)),
      .wdata     (wr_data),
      .task_sw   (task_sw),
      .exc_entry (exc_entry),
      .ctl_q     (ctl_q)
   );

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [ADDR_W-1:0] addr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    addr_q <= '0;
         else if (wr_ok && (sel == reg_sel_e'(3'(i))))  addr_q <= wr_data[ADDR_W-1:0];
      end
      assign bp_rd[i]   = REG_W'(addr_q);
      assign slot_en[i] = ctl_q[2*i] | ctl_q[2*i+1];
   end

   always_comb begin
      case (sel)
         SEL_STAT: rd_mux = stat_q;
         SEL_CTRL: rd_mux = ctl_q;
         SEL_NONE: rd_mux = '0;
         default:  rd_mux = bp_rd[sel[1:0]];
      endcase
   end

   assign rd_data = rd_ok ? rd_mux : '0;
   assign dbg_req = guard_trap | step_evt | trap_evt | lock_evt | (|(bp_hit & slot_en));

endmodule

// File: rtl/brkpt_regbank_chk.sv
module brkpt_regbank_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  reg_num,
   input logic        rd_en,
   input logic        wr_en,
   input logic [1:0]  cpl,
   input logic        ext_en,
   input logic        task_sw,
   input logic        exc_entry,
   input logic [31:0] rd_data,
   input logic        prot_fault,
   input logic        undef_fault,
   input logic        dbg_req,
   input logic [31:0] stat_q,
   input logic [31:0] ctl_q
);

   logic access;
   logic legacy;
   assign access = rd_en | wr_en;
   assign legacy = (reg_num == 3'd4) || (reg_num == 3'd5);

   assert_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      access && (cpl != 2'd0) |-> prot_fault && !undef_fault && (rd_data == 32'd0));

   assert_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
      access && (cpl == 2'd0) && ctl_q[13] && !(ext_en && legacy) |-> dbg_req && (rd_data == 32'd0));

   assert_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry |=> stat_q[13] && !ctl_q[13]);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> (($past(stat_q[15:13]) & ~stat_q[15:13]) == 3'b000)
                      && (($past(stat_q[3:0]) & ~stat_q[3:0]) == 4'b0000));

   assert_lock_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[11]) |-> $past(wr_en));

   assert_tasksw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      task_sw |=> ((ctl_q & 32'h0000_0055) == 32'd0));

   assert_ctl_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[10] && (ctl_q[15:14] == 2'b00) && (ctl_q[12:11] == 2'b00));

   assert_stat_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[10:4] == 7'h7F) && !stat_q[12] && (stat_q[31:17] == 15'h7FFF));

   assert_fault_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prot_fault, undef_fault}));

endmodule

bind brkpt_regbank brkpt_regbank_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_num     (reg_num),
   .rd_en       (rd_en),
   .wr_en       (wr_en),
   .cpl         (cpl),
   .ext_en      (ext_en),
   .task_sw     (task_sw),
   .exc_entry   (exc_entry),
   .rd_data     (rd_data),
   .prot_fault  (prot_fault),
   .undef_fault (undef_fault),
   .dbg_req     (dbg_req),
   .stat_q      (stat_q),
   .ctl_q       (ctl_q)
);

// File: tb/test_brkpt_regbank.sv
`timescale 1ns/1ps
module test_brkpt_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_num = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  cpl = '0;
   logic        ext_en = 1'b0;
   logic [3:0]  bp_hit = '0;
   logic        step_evt = 1'b0, trap_evt = 1'b0, lock_evt = 1'b0, task_sw = 1'b0, exc_entry = 1'b0;
   logic        prot_fault, undef_fault, dbg_req;

   always #2 clk = ~clk;

   brkpt_regbank i_brkpt_regbank (
      .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .cpl(cpl), .ext_en(ext_en), .bp_hit(bp_hit),
      .step_evt(step_evt), .trap_evt(trap_evt), .lock_evt(lock_evt), .task_sw(task_sw),
      .exc_entry(exc_entry), .prot_fault(prot_fault), .undef_fault(undef_fault), .dbg_req(dbg_req)
   );

   // reference model, values from the requirements
   localparam logic [31:0] S_WMASK = 32'h0000_E80F;
   localparam logic [31:0] S_FIXED = 32'hFFFF_07F0;
   localparam logic [31:0] C_WMASK = 32'hFFFF_23FF;
   localparam logic [31:0] C_FIXED = 32'h0000_0400;

   logic [31:0] m_bp [4];
   logic [31:0] m_stat, m_ctl;
   int nchk = 0, nerr = 0;
   bit done = 0;

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input logic [2:0] n, input logic r, input logic w, input logic [31:0] d,
                      input logic [1:0] p, input logic x, input logic [3:0] h,
                      input logic st, input logic tr, input logic lk, input logic ts,
                      input logic ex, input string tag_in);
      logic acc, prot, und, gdt, ok, ereq;
      logic [2:0] en_n;
      logic [3:0] slot_en;
      logic [31:0] val, erd;
      string tag;
      @(negedge clk);
      reg_num = n; rd_en = r; wr_en = w; wr_data = d; cpl = p; ext_en = x; bp_hit = h;
      step_evt = st; trap_evt = tr; lock_evt = lk; task_sw = ts; exc_entry = ex;
      #1;
      acc  = r | w;
      prot = acc && (p != 2'd0);
      und  = acc && !prot && x && (n == 3'd4 || n == 3'd5);
      gdt  = acc && !prot && !und && m_ctl[13];
      ok   = acc && !prot && !und && !gdt;
      en_n = (n == 3'd4) ? 3'd6 : (n == 3'd5) ? 3'd7 : n;
      val  = (en_n < 3'd4) ? m_bp[en_n[1:0]] : (en_n == 3'd6) ? m_stat : m_ctl;
      erd  = (r && ok) ? val : 32'd0;
      for (int i = 0; i < 4; i++) slot_en[i] = m_ctl[2*i] | m_ctl[2*i+1];
      ereq = gdt | st | tr | lk | (|(h & slot_en));
      if (tag_in != "") tag = tag_in;
      else if (prot) tag = "R2";
      else if (und) tag = "R11";
      else if (gdt) tag = "R3";
      else if (n == 3'd4 || n == 3'd5) tag = "R1";
      else if (en_n == 3'd6) tag = "R10";
      else if (en_n == 3'd7) tag = "R9";
      else tag = "R13";
      check(tag, "rd_data", rd_data, erd);
      check(tag, "prot_fault", {31'd0, prot_fault}, {31'd0, prot});
      check(tag, "undef_fault", {31'd0, undef_fault}, {31'd0, und});
      check(tag, "dbg_req", {31'd0, dbg_req}, {31'd0, ereq});
      // next state
      if (w && ok) begin
         if (en_n < 3'd4) m_bp[en_n[1:0]] = d;
         else if (en_n == 3'd6) m_stat = (m_stat & ~S_WMASK) | (d & S_WMASK);
         else m_ctl = (m_ctl & ~C_WMASK) | (d & C_WMASK);
      end
      m_stat[3:0] = m_stat[3:0] | h;
      if (st) m_stat[14] = 1'b1;
      if (tr) m_stat[15] = 1'b1;
      if (ex) m_stat[13] = 1'b1;
      if (lk) m_stat[11] = 1'b0;
      m_stat = (m_stat & S_WMASK) | S_FIXED;
      if (ts) m_ctl = m_ctl & ~32'h55;
      if (ex) m_ctl[13] = 1'b0;
      m_ctl = (m_ctl & C_WMASK) | C_FIXED;
   endtask

   task automatic rd(input logic [2:0] n, input string tag);
      cyc(n, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic wr(input logic [2:0] n, input logic [31:0] d, input string tag);
      cyc(n, 0, 1, d, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd20240);
      for (int i = 0; i < 4; i++) m_bp[i] = '0;
      m_stat = 32'hFFFF_0FF0;
      m_ctl  = 32'h0000_0400;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // reset values
      rd(0, "R12"); rd(3, "R12"); rd(6, "R12"); rd(7, "R12");
      // map, alias
      wr(2, 32'hCAFE_1234, "R1"); rd(2, "R1");
      rd(4, "R1");
      wr(5, 32'hFFFF_DFFF, "R9"); rd(7, "R9"); rd(5, "R1");
      // privilege
      cyc(0, 0, 1, 32'h1111_2222, 2'd3, 0, 0, 0, 0, 0, 0, 0, "R2");
      rd(0, "R2");
      // undefined numbers with extensions on, privilege wins over undefined
      cyc(4, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R11");
      cyc(5, 0, 1, 0, 2'd1, 1, 0, 0, 0, 0, 0, 0, "R11");
      // access guard and handler entry
      wr(7, 32'h0000_2000, "R3");
      rd(1, "R3");
      wr(1, 32'h5555_5555, "R3");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R4");
      rd(6, "R4"); rd(7, "R4"); rd(1, "R3");
      // events and stickiness
      wr(6, 32'h0, "R6");
      wr(7, 32'h0000_0003, "R13");
      cyc(0, 0, 0, 0, 0, 0, 4'b0101, 1, 1, 0, 0, 0, "R5");
      cyc(0, 0, 0, 0, 0, 0, 4'b0010, 0, 0, 0, 0, 0, "R13");
      rd(6, "R5");
      repeat (3) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
      rd(6, "R6");
      // write merged with event in the same cycle
      cyc(6, 0, 1, 32'h0, 0, 0, 4'b1000, 1, 0, 0, 0, 0, "R13");
      rd(6, "R6");
      // bus lock
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
      rd(6, "R7");
      repeat (2) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      rd(6, "R7");
      wr(6, 32'h0000_0800, "R7"); rd(6, "R7");
      // task switch
      wr(7, 32'hFFFF_00FF, "R8");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
      rd(7, "R8");
      // fixed status bits
      wr(6, 32'hFFFF_FFFF, "R10"); rd(6, "R10");
      wr(6, 32'h0, "R10"); rd(6, "R10");

      // constrained random
      for (int k = 0; k < 4000; k++) begin
         logic [2:0] n;
         logic [31:0] d;
         logic [1:0] p;
         n = 3'($urandom % 8);
         d = $urandom;
         if (n == 3'd7 || n == 3'd5) if (($urandom % 8) != 0) d[13] = 1'b0;
         p = (($urandom % 8) == 0) ? 2'(1 + ($urandom % 3)) : 2'd0;
         cyc(n, ($urandom % 2) == 0, ($urandom % 3) == 0, d, p, ($urandom % 4) == 0,
             (($urandom % 6) == 0) ? 4'($urandom) : 4'd0,
             ($urandom % 10) == 0, ($urandom % 10) == 0, ($urandom % 12) == 0,
             ($urandom % 10) == 0, ($urandom % 12) == 0, "");
      end
      finish_run();
   end

endmodule